// File: doc/BRIEF.md
# Display Controller Interrupt Aggregator

This block gathers the single-cycle event pulses of a display controller into eight sticky status bits. An eight-bit enable mask gates those bits, and the block drives one registered interrupt request line to the host. The host reads three things: the raw status, the masked status and the mask. It clears status bits by writing ones to them.

Two sources are derived inside the block rather than taken as ready-made pulses:

- **AC-bias counter.** It is loaded from a programmable count and steps down on each toggle of the AC-bias line. When it reaches zero it flags an event. It then stays frozen until the host acknowledges that event.
- **Shared frame-done event.** It follows the operating mode:
  - In raster mode it fires once, on the first frame that completes after the raster enable falls.
  - In character-panel mode it fires once per enable period of the character DMA.

The DMA engine, the pixel pipeline and the panel timing logic are outside this block. They supply only event pulses and mode and enable levels.

Top module: `disp_irq_agg`

## Requirements
- R1: The status bit positions are fixed as follows: 0 end of buffer 0, 1 end of buffer 1, 2 palette loaded, 3 FIFO underflow, 4 sync lost, 5 AC-bias count reached, 6 recurrent frame done, 7 shared done. A pulse on any of the inputs for bits 0, 1, 3 and 4 sets that bit at the next clock edge. The bit then stays set until it is cleared.
- R2: A cycle with `clr_wr_i` high clears every status bit whose `clr_wdata_i` bit is 1. If a bit is set and cleared in the same cycle, it ends up set.
- R3: A palette pulse sets bit 2 only while `pal_mode_i` is 1 (palette only) or 2 (palette plus data). Values 0 (data only) and 3 leave bit 2 unchanged.
- R4: Each `acb_toggle_i` pulse decrements the AC-bias counter. The toggle that takes the counter from 1 to 0 sets bit 5. A programmed count of 0 never sets bit 5.
- R5: While bit 5 is set, the counter holds its value and ignores toggles. Clearing bit 5 reloads the counter from `acb_count_i`, and counting resumes from that value.
- R6: In raster mode (`raster_mode_i`=1), every `frame_sent_i` pulse sets bit 6. In character mode it has no effect on bit 6.
- R7: In raster mode, bit 7 is set exactly once, by the first `frame_sent_i` at or after the cycle in which `raster_en_i` falls. Frames sent while the enable is high do not set it.
- R8: In character mode, `chr_buf_done_i` sets bit 7 while `chr_dma_en_i` is high, but only once per enable period. A further event requires `chr_dma_en_i` to go low and then high again.
- R9: A cycle with `mask_wr_i` high loads `mask_wdata_i` into the mask, which is shown on `mask_o`. `masked_status_o` equals the raw status ANDed with the mask.
- R10: `irq_o` is the OR of the masked status bits, delayed by one clock cycle.
- R11: A synchronous active-low reset clears the status, the mask and `irq_o`, and loads the AC-bias counter from `acb_count_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_eob0_i | input | 1 | Frame buffer 0 transfer finished pulse |
| ev_eob1_i | input | 1 | Frame buffer 1 transfer finished pulse |
| ev_pal_i | input | 1 | Palette written to palette RAM pulse |
| pal_mode_i | input | 2 | Palette mode: 0 data, 1 palette only, 2 palette plus data |
| ev_underflow_i | input | 1 | FIFO underflow pulse |
| ev_sync_lost_i | input | 1 | Frame start marker missing pulse |
| acb_toggle_i | input | 1 | AC-bias line toggle pulse |
| acb_count_i | input | 8 | Programmed AC-bias toggle count |
| raster_mode_i | input | 1 | 1 raster mode, 0 character-panel mode |
| raster_en_i | input | 1 | Raster enable level |
| frame_sent_i | input | 1 | Full frame has left the output pins pulse |
| chr_dma_en_i | input | 1 | Character-panel DMA enable level |
| chr_buf_done_i | input | 1 | Character-panel frame buffer sent pulse |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| clr_wr_i | input | 1 | Status clear strobe |
| clr_wdata_i | input | 8 | Write-one-to-clear data |
| raw_status_o | output | 8 | Sticky status bits |
| masked_status_o | output | 8 | Status ANDed with mask |
| mask_o | output | 8 | Current mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following:

- Status bits stay set, and a set wins over a simultaneous clear.
- The request line trails the masked status by exactly one cycle.
- The AC-bias counter is frozen while its event is pending.
- Palette pulses in non-palette modes leave bit 2 untouched.
- The shared done fires only once before it is re-armed.

Some behaviour shows only in the bench's ordered scenarios:

- The exact toggle on which the AC-bias event fires.
- Reload and resumption of the counter after a clear.
- The "first frame after the enable falls" rule in raster mode.
- The disable-then-enable re-arm in character mode.

// File: rtl/disp_irq_pkg.sv
// Package: shared widths and status bit positions for the display
// interrupt aggregator. Bit positions are visible to software.
package disp_irq_pkg;
    localparam int NSRC      = 8;
    localparam int B_EOB0    = 0;
    localparam int B_EOB1    = 1;
    localparam int B_PAL     = 2;
    localparam int B_UFLOW   = 3;
    localparam int B_SYNC    = 4;
    localparam int B_ACB     = 5;
    localparam int B_REC     = 6;
    localparam int B_DONE    = 7;

    localparam logic [1:0] PAL_DATA_ONLY = 2'd0;
    localparam logic [1:0] PAL_ONLY      = 2'd1;
    localparam logic [1:0] PAL_AND_DATA  = 2'd2;
endpackage

// File: rtl/acb_counter.sv
// AC-bias toggle counter.
// Counts toggles down from a programmed value and pulses hit_o on the
// toggle that reaches zero. Assumes pending_i is the sticky status bit
// that hit_o sets; while it is high the count is frozen. reload_i
// (the host clearing that bit) reloads the programmed value. A count
// of zero is idle and never produces a hit.
module acb_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          toggle_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          pending_i,
    input  logic          reload_i,
    output logic          hit_o
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    logic [CW-1:0] cnt_q;
    logic          step;

    // A toggle counts only when no event is pending and no reload is in progress.
    assign step  = toggle_i && !pending_i && !reload_i && (cnt_q != ZERO);
    assign hit_o = step && (cnt_q == ONE);

    // Count register: load on reset or reload, decrement on a counted toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= load_val_i;
        end else if (reload_i) begin
            cnt_q <= load_val_i;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    AST_ACB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i && !reload_i) |=> $stable(cnt_q)); // R5
    AST_ACB_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (cnt_q == ZERO)); // R4
endmodule

// File: rtl/frame_done_ctrl.sv
// Frame-done event generation.
// Produces the recurrent frame event (raster mode only) and the shared
// done event. In raster mode the shared done fires once, on the first
// sent frame at or after the fall of the raster enable. In character
// mode it fires once per high period of the character DMA enable.
// Assumes all inputs are synchronous to clk.
module frame_done_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic raster_mode_i,
    input  logic raster_en_i,
    input  logic frame_sent_i,
    input  logic chr_en_i,
    input  logic chr_done_i,
    output logic rec_o,
    output logic done_o
);
    logic en_q;
    logic stop_pend_q;
    logic armed_q;
    logic en_fall;
    logic raster_done;
    logic chr_done;

    assign en_fall     = en_q && !raster_en_i;
    assign raster_done = raster_mode_i && frame_sent_i && (stop_pend_q || en_fall);
    assign chr_done    = !raster_mode_i && chr_en_i && chr_done_i && armed_q;
    assign rec_o       = raster_mode_i && frame_sent_i;
    assign done_o      = raster_done || chr_done;

    // Enable history and the pending-stop flag for raster shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            stop_pend_q <= 1'b0;
        end else begin
            en_q <= raster_en_i;
            if (raster_done)     stop_pend_q <= 1'b0;
            else if (en_fall)    stop_pend_q <= 1'b1;
            else if (raster_en_i) stop_pend_q <= 1'b0;
        end
    end

    // Character DMA re-arm: armed while the enable is low, spent on done.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b1;
        else if (!chr_en_i) armed_q <= 1'b1;
        else if (chr_done)  armed_q <= 1'b0;
    end

    AST_RASTER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && raster_mode_i && !raster_en_i) |=> !(done_o && raster_mode_i)); // R7
    AST_CHR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !raster_mode_i) |=> !(done_o && !raster_mode_i)); // R8
endmodule

// File: rtl/irq_status_bank.sv
// Sticky status bank with mask and registered request.
// One write-one-to-clear bit per source (set wins), a mask register
// and a request flop fed by the OR of masked bits. Assumes set_i are
// single-cycle pulses and clr_i is already qualified by the write strobe.
module irq_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] status_q;
    logic [N-1:0] mask_q;
    logic         irq_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-source sticky bit: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        status_q[i] <= 1'b0;
            else if (set_i[i]) status_q[i] <= 1'b1;
            else if (clr_i[i]) status_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> status_q[i]); // R2
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr_i[i]) |=> status_q[i]); // R1
    end

    // Mask register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= mask_wdata_i;
    end

    // Request flop: OR of masked status, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & mask_q);
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = irq_q;

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(status_o) & $past(mask_o)))); // R10
endmodule

// File: rtl/disp_irq_agg.sv
// Display controller interrupt aggregator (top).
// Routes event pulses into the status bank and gates the palette
// pulse by the palette mode. It also derives the AC-bias and
// frame-done events in submodules. Assumes all inputs are synchronous
// and that event inputs are single-cycle pulses.
module disp_irq_agg
    import disp_irq_pkg::*;
#(
    parameter int ACB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_eob0_i,
    input  logic             ev_eob1_i,
    input  logic             ev_pal_i,
    input  logic [1:0]       pal_mode_i,
    input  logic             ev_underflow_i,
    input  logic             ev_sync_lost_i,
    input  logic             acb_toggle_i,
    input  logic [ACB_W-1:0] acb_count_i,
    input  logic             raster_mode_i,
    input  logic             raster_en_i,
    input  logic             frame_sent_i,
    input  logic             chr_dma_en_i,
    input  logic             chr_buf_done_i,
    input  logic             mask_wr_i,
    input  logic [NSRC-1:0]  mask_wdata_i,
    input  logic             clr_wr_i,
    input  logic [NSRC-1:0]  clr_wdata_i,
    output logic [NSRC-1:0]  raw_status_o,
    output logic [NSRC-1:0]  masked_status_o,
    output logic [NSRC-1:0]  mask_o,
    output logic             irq_o
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic            pal_ok;
    logic            acb_hit;
    logic            rec_ev;
    logic            done_ev;

    assign pal_ok  = (pal_mode_i == PAL_ONLY) || (pal_mode_i == PAL_AND_DATA);
    assign clr_vec = clr_wr_i ? clr_wdata_i : '0;

    // Assemble per-source set pulses in status bit order.
    always_comb begin
        set_vec          = '0;
        set_vec[B_EOB0]  = ev_eob0_i;
        set_vec[B_EOB1]  = ev_eob1_i;
        set_vec[B_PAL]   = ev_pal_i && pal_ok;
        set_vec[B_UFLOW] = ev_underflow_i;
        set_vec[B_SYNC]  = ev_sync_lost_i;
        set_vec[B_ACB]   = acb_hit;
        set_vec[B_REC]   = rec_ev;
        set_vec[B_DONE]  = done_ev;
    end

    acb_counter #(.CW(ACB_W)) u_acb (
        .clk        (clk),
        .rst_n      (rst_n),
        .toggle_i   (acb_toggle_i),
        .load_val_i (acb_count_i),
        .pending_i  (raw_status_o[B_ACB]),
        .reload_i   (clr_vec[B_ACB]),
        .hit_o      (acb_hit)
    );

    frame_done_ctrl u_fdone (
        .clk           (clk),
        .rst_n         (rst_n),
        .raster_mode_i (raster_mode_i),
        .raster_en_i   (raster_en_i),
        .frame_sent_i  (frame_sent_i),
        .chr_en_i      (chr_dma_en_i),
        .chr_done_i    (chr_buf_done_i),
        .rec_o         (rec_ev),
        .done_o        (done_ev)
    );

    irq_status_bank #(.N(NSRC)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_vec),
        .clr_i        (clr_vec),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .status_o     (raw_status_o),
        .mask_o       (mask_o),
        .irq_o        (irq_o)
    );

    assign masked_status_o = raw_status_o & mask_o;

    AST_PAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pal_i && !pal_ok && !clr_vec[B_PAL]) |=> $stable(raw_status_o[B_PAL])); // R3
    AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_status_o & ~raw_status_o) == '0)); // R9
endmodule

// File: tb/disp_irq_agg_test.sv
`timescale 1ns/1ps
module disp_irq_agg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_eob0 = 0, ev_eob1 = 0, ev_pal = 0, ev_uf = 0, ev_sync = 0;
    logic [1:0] pal_mode = 2'd0;
    logic       acb_tog = 0;
    logic [7:0] acb_cnt = 8'd3;
    logic       r_mode = 0, r_en = 0, f_sent = 0, c_en = 0, c_done = 0;
    logic       m_wr = 0, c_wr = 0;
    logic [7:0] m_data = '0, c_data = '0;
    logic [7:0] raw, masked, mask;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    disp_irq_agg uut (
        .clk(clk), .rst_n(rst_n),
        .ev_eob0_i(ev_eob0), .ev_eob1_i(ev_eob1), .ev_pal_i(ev_pal),
        .pal_mode_i(pal_mode), .ev_underflow_i(ev_uf), .ev_sync_lost_i(ev_sync),
        .acb_toggle_i(acb_tog), .acb_count_i(acb_cnt),
        .raster_mode_i(r_mode), .raster_en_i(r_en), .frame_sent_i(f_sent),
        .chr_dma_en_i(c_en), .chr_buf_done_i(c_done),
        .mask_wr_i(m_wr), .mask_wdata_i(m_data),
        .clr_wr_i(c_wr), .clr_wdata_i(c_data),
        .raw_status_o(raw), .masked_status_o(masked), .mask_o(mask), .irq_o(irq)
    );

    // Vector: {ev[3:0] = sync,uf,eob1,eob0 ; clear[7:0] ; expected raw[7:0]}
    localparam logic [19:0] VEC [8] = '{
        {4'b0001, 8'h00, 8'h01},
        {4'b1000, 8'h00, 8'h11},
        {4'b0000, 8'h01, 8'h10},
        {4'b0110, 8'h10, 8'h0A},
        {4'b0010, 8'h02, 8'h0A},
        {4'b0000, 8'hFF, 8'h00},
        {4'b1111, 8'h00, 8'h1B},
        {4'b0000, 8'h08, 8'h13}
    };
    localparam logic [7:0] LOOP_MASK = 8'h13;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock; drive before, clear pulses after, sample at negedge.
    task automatic tick();
        @(negedge clk);
        {ev_eob0, ev_eob1, ev_pal, ev_uf, ev_sync, acb_tog, f_sent, c_done, m_wr, c_wr} = '0;
    endtask

    task automatic clear_bits(input logic [7:0] b);
        c_wr = 1; c_data = b; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] prev_masked;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R11 status", raw, 8'h00);
        chk("R11 mask", mask, 8'h00);
        chk("R11 irq", {7'b0, irq}, 8'h00);

        m_wr = 1; m_data = LOOP_MASK; tick();
        chk("R9 mask readback", mask, LOOP_MASK);

        prev_masked = 8'h00;
        for (int v = 0; v < 8; v++) begin
            {ev_sync, ev_uf, ev_eob1, ev_eob0} = VEC[v][19:16];
            c_wr = 1; c_data = VEC[v][15:8];
            tick();
            chk("R1/R2 raw", raw, VEC[v][7:0]);
            chk("R9 masked", masked, VEC[v][7:0] & LOOP_MASK);
            chk("R10 irq lag", {7'b0, irq}, {7'b0, |prev_masked});
            prev_masked = VEC[v][7:0] & LOOP_MASK;
        end
        clear_bits(8'hFF);

        // R3 palette gating
        pal_mode = 2'd0; ev_pal = 1; tick(); chk("R3 data-only", raw & 8'h04, 8'h00);
        pal_mode = 2'd3; ev_pal = 1; tick(); chk("R3 mode3", raw & 8'h04, 8'h00);
        pal_mode = 2'd1; ev_pal = 1; tick(); chk("R3 palette-only", raw & 8'h04, 8'h04);
        clear_bits(8'h04);
        pal_mode = 2'd2; ev_pal = 1; tick(); chk("R3 palette+data", raw & 8'h04, 8'h04);
        clear_bits(8'h04);

        // R4/R5 AC-bias counter, count 3 loaded at reset
        acb_tog = 1; tick(); acb_tog = 1; tick();
        chk("R4 two toggles", raw & 8'h20, 8'h00);
        acb_tog = 1; tick();
        chk("R4 third toggle", raw & 8'h20, 8'h20);
        for (int k = 0; k < 4; k++) begin acb_tog = 1; tick(); end
        chk("R5 held pending", raw & 8'h20, 8'h20);
        clear_bits(8'h20);
        chk("R5 cleared", raw & 8'h20, 8'h00);
        acb_tog = 1; tick(); acb_tog = 1; tick();
        chk("R5 reload two toggles", raw & 8'h20, 8'h00);
        acb_tog = 1; tick();
        chk("R5 reload third toggle", raw & 8'h20, 8'h20);
        acb_cnt = 8'd0;
        clear_bits(8'h20);
        for (int k = 0; k < 4; k++) begin acb_tog = 1; tick(); end
        chk("R4 zero count idle", raw & 8'h20, 8'h00);

        // R6 recurrent frame done
        r_mode = 1; f_sent = 1; tick();
        chk("R6 raster frame", raw & 8'h40, 8'h40);
        clear_bits(8'h40);
        r_mode = 0; f_sent = 1; tick();
        chk("R6 char no effect", raw & 8'h40, 8'h00);

        // R7 raster shared done
        r_mode = 1; r_en = 1; tick();
        f_sent = 1; tick();
        chk("R7 enabled frame", raw & 8'h80, 8'h00);
        clear_bits(8'hFF);
        r_en = 0; tick();
        chk("R7 after fall no frame", raw & 8'h80, 8'h00);
        f_sent = 1; tick();
        chk("R7 last frame", raw & 8'h80, 8'h80);
        clear_bits(8'hFF);
        f_sent = 1; tick();
        chk("R7 only once", raw & 8'h80, 8'h00);
        clear_bits(8'hFF);

        // R8 character mode done
        r_mode = 0; c_en = 1; c_done = 1; tick();
        chk("R8 first buffer", raw & 8'h80, 8'h80);
        clear_bits(8'h80);
        c_done = 1; tick();
        chk("R8 no rearm", raw & 8'h80, 8'h00);
        c_en = 0; tick();
        c_en = 1; c_done = 1; tick();
        chk("R8 rearmed", raw & 8'h80, 8'h80);

        // R10 request follows mask one cycle late
        m_wr = 1; m_data = 8'h80; tick();
        chk("R10 irq before", {7'b0, irq}, 8'h00);
        chk("R9 masked bit7", masked, 8'h80);
        tick();
        chk("R10 irq asserted", {7'b0, irq}, 8'h01);
        clear_bits(8'h80);
        chk("R10 irq lags clear", {7'b0, irq}, 8'h01);
        tick();
        chk("R10 irq dropped", {7'b0, irq}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule